// File: doc/BRIEF.md
# MMU Fault Status Recorder

This block records a failed physical access (an unmapped physical address, or an alternate address space that nothing serves) in two registers. A fault status register holds a fixed-format word that describes the access. A fault address register holds the physical address that failed. The block also decides whether the fault must trap the processor. The trap is raised only while the MMU is enabled and not in no-fault mode. An instruction fetch raises a code-access trap; any other access raises a data-access trap.

Software reads the status through a read strobe. The read returns the current word and clears the register. A second fault that arrives before software has read the first one is marked as an overflow in the new word. A read and a fault in the same cycle record the new fault into a cleared register.

Top module: `mmu_fault_rec`

## Requirements
- R1: While reset is low, and on the first cycle after it, `faultStatus`, `faultAddrReg`, `codeTrap` and `dataTrap` are all zero.
- R2: The status word written by every fault has bit 1 set (address valid) and bits 4:2 equal to 3'b101 (fault type 5). A fault into an empty register with no qualifiers therefore gives 32'h16.
- R3: In the status word a fault writes, bit 7 is the write qualifier, bit 6 the instruction-fetch qualifier, bit 5 the supervisor bit and bit 16 the alternate-space qualifier. Every other bit is zero, except bits 4:1 (R2) and bit 0 (R4).
- R4: A fault that arrives without a read while the status register is nonzero discards the old word. It writes the new word with bit 0 set to mark overflow.
- R5: Every fault loads its address into `faultAddrReg` on the clock edge that samples it. Without a fault the register holds its value.
- R6: `statusRdata` equals `faultStatus` in every cycle. A read without a fault clears the status to zero at the next edge. With neither a read nor a fault the status holds.
- R7: A fault that arrives together with a read writes the new word into a cleared register, with bit 0 zero.
- R8: In the cycle after a fault, `codeTrap` pulses if the fault was an instruction fetch, and `dataTrap` pulses if it was not. Neither pulses unless `mmuCtrl[0]` (enable) is 1 and `mmuCtrl[1]` (no-fault) is 0 at the time of the fault.
- R9: Each trap output is high for a single cycle per fault, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| faultValid | input | 1 | A failed access is reported this cycle |
| faultAddr | input | ADDR_W | Physical address of the failed access |
| faultWrite | input | 1 | The access was a store |
| faultExec | input | 1 | The access was an instruction fetch |
| faultAlt | input | 1 | The access used an alternate address space |
| supervisor | input | 1 | The processor is in supervisor mode |
| mmuCtrl | input | 2 | Bit 0 MMU enable, bit 1 no-fault mode |
| statusRead | input | 1 | Read-and-clear strobe for the status register |
| statusRdata | output | 32 | Read data of the status register |
| faultStatus | output | 32 | Status register contents |
| faultAddrReg | output | ADDR_W | Fault address register contents |
| codeTrap | output | 1 | Code-access trap request pulse |
| dataTrap | output | 1 | Data-access trap request pulse |

## Verification
Some properties are checked on every cycle: the fixed type and valid bits, the copying of qualifiers into their bit positions, the overflow mark with and without a coincident read, clear-on-read, holding when idle, loading of the address, and the trap gating and exclusivity. The bench scenarios are needed for the rest. They show that an overflowing fault discards the previous qualifier bits, and that a trap lasts only one cycle across back-to-back faults. They also show that a mid-run reset empties both registers.

// File: rtl/mmu_fault_pkg.sv
package mmu_fault_pkg;
  localparam int STAT_W    = 32;
  localparam int OVF_BIT   = 0;
  localparam int VALID_BIT = 1;
  localparam int TYPE_LO   = 2;
  localparam int TYPE_W    = 3;
  localparam int SUP_BIT   = 5;
  localparam int EXEC_BIT  = 6;
  localparam int WR_BIT    = 7;
  localparam int ALT_BIT   = 16;
  localparam logic [TYPE_W-1:0] FAULT_TYPE = 3'd5;
  localparam int CTRL_W    = 2;
  localparam int EN_BIT    = 0;
  localparam int NF_BIT    = 1;

  typedef struct packed {
    logic capture;
    logic markOvf;
    logic clear;
  } strobe_t;
endpackage

// File: rtl/mfr_ctrl.sv
module mfr_ctrl
  import mmu_fault_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              faultValid,
  input  logic              faultExec,
  input  logic              statusRead,
  input  logic              statusNonZero,
  input  logic [CTRL_W-1:0] mmuCtrl,
  output strobe_t           stb,
  output logic              codeTrap,
  output logic              dataTrap
);
  logic trapAllowed;

  always_comb begin
    trapAllowed = mmuCtrl[EN_BIT] && !mmuCtrl[NF_BIT];
    stb.capture = faultValid;
    stb.markOvf = faultValid && statusNonZero && !statusRead;
    stb.clear   = statusRead && !faultValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeTrap <= 1'b0;
      dataTrap <= 1'b0;
    end else begin
      codeTrap <= faultValid && trapAllowed && faultExec;
      dataTrap <= faultValid && trapAllowed && !faultExec;
    end
  end
endmodule

// File: rtl/mfr_dpath.sv
module mfr_dpath
  import mmu_fault_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] faultAddr,
  input  logic              faultWrite,
  input  logic              faultExec,
  input  logic              faultAlt,
  input  logic              supervisor,
  output logic [STAT_W-1:0] statusQ,
  output logic [ADDR_W-1:0] addrQ,
  output logic              statusNonZero
);
  logic [STAT_W-1:0] newWord;

  always_comb begin
    newWord = '0;
    newWord[OVF_BIT] = stb.markOvf;
    newWord[VALID_BIT] = 1'b1;
    newWord[TYPE_LO +: TYPE_W] = FAULT_TYPE;
    newWord[SUP_BIT] = supervisor;
    newWord[EXEC_BIT] = faultExec;
    newWord[WR_BIT] = faultWrite;
    newWord[ALT_BIT] = faultAlt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      addrQ   <= '0;
    end else begin
      if (stb.capture) begin
        statusQ <= newWord;
        addrQ   <= faultAddr;
      end else if (stb.clear) begin
        statusQ <= '0;
      end
    end
  end

  assign statusNonZero = |statusQ;
endmodule

// File: rtl/mmu_fault_rec.sv
module mmu_fault_rec
  import mmu_fault_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              faultValid,
  input  logic [ADDR_W-1:0] faultAddr,
  input  logic              faultWrite,
  input  logic              faultExec,
  input  logic              faultAlt,
  input  logic              supervisor,
  input  logic [1:0]        mmuCtrl,
  input  logic              statusRead,
  output logic [31:0]       statusRdata,
  output logic [31:0]       faultStatus,
  output logic [ADDR_W-1:0] faultAddrReg,
  output logic              codeTrap,
  output logic              dataTrap
);
  strobe_t stb;
  logic    statusNonZero;

  mfr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .faultValid(faultValid), .faultExec(faultExec),
    .statusRead(statusRead), .statusNonZero(statusNonZero), .mmuCtrl(mmuCtrl),
    .stb(stb), .codeTrap(codeTrap), .dataTrap(dataTrap)
  );

  mfr_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .faultAddr(faultAddr),
    .faultWrite(faultWrite), .faultExec(faultExec), .faultAlt(faultAlt),
    .supervisor(supervisor), .statusQ(faultStatus), .addrQ(faultAddrReg),
    .statusNonZero(statusNonZero)
  );

  assign statusRdata = faultStatus;
endmodule

// File: rtl/mmu_fault_rec_chk.sv
module mmu_fault_rec_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              faultValid,
  input logic [ADDR_W-1:0] faultAddr,
  input logic              faultWrite,
  input logic              faultExec,
  input logic              faultAlt,
  input logic              supervisor,
  input logic [1:0]        mmuCtrl,
  input logic              statusRead,
  input logic [31:0]       statusRdata,
  input logic [31:0]       faultStatus,
  input logic [ADDR_W-1:0] faultAddrReg,
  input logic              codeTrap,
  input logic              dataTrap
);
  AST_TYPE_VALID: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |=> faultStatus[4:1] == 4'b1011); // R2
  AST_QUALIFIERS: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |=> (faultStatus[7] == $past(faultWrite)) && (faultStatus[6] == $past(faultExec))
                && (faultStatus[5] == $past(supervisor)) && (faultStatus[16] == $past(faultAlt))); // R3
  AST_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && !statusRead && faultStatus != 0) |=> faultStatus[0]); // R4
  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |=> faultAddrReg == $past(faultAddr)); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !faultValid |=> $stable(faultAddrReg)); // R5
  AST_CLEAR_READ: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !faultValid) |=> faultStatus == 0); // R6
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!statusRead && !faultValid) |=> $stable(faultStatus)); // R6
  AST_RDATA: assert property (@(posedge clk) disable iff (!rstN)
    statusRdata == faultStatus); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && (statusRead || faultStatus == 0)) |=> !faultStatus[0]); // R7
  AST_TRAP_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (codeTrap || dataTrap) |-> $past(faultValid && mmuCtrl[0] && !mmuCtrl[1])); // R8
  AST_TRAP_KIND: assert property (@(posedge clk) disable iff (!rstN)
    codeTrap |-> $past(faultExec)); // R8
  AST_TRAP_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $countones({codeTrap, dataTrap}) <= 1); // R9
endmodule

bind mmu_fault_rec mmu_fault_rec_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_mmu_fault_rec.sv
module sim_mmu_fault_rec;
  logic        clk = 1'b0;
  logic        rstN;
  logic        faultValid, faultWrite, faultExec, faultAlt, supervisor, statusRead;
  logic [31:0] faultAddr;
  logic [1:0]  mmuCtrl;
  logic [31:0] statusRdata, faultStatus, faultAddrReg;
  logic        codeTrap, dataTrap;
  int          nRun = 0;
  int          nFail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  mmu_fault_rec u0 (.*);

  typedef struct packed {
    logic        flt, wr, ex, alt, sup;
    logic [1:0]  ctl;
    logic        rd;
    logic [31:0] addr;
    logic [31:0] expSt;
    logic [31:0] expAddr;
    logic        expCode, expData;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TABLE [NV] = '{
    '{1,1,0,0,0,2'b01,0, 32'h1000_0004, 32'h0000_0096, 32'h1000_0004, 0,1}, // R2 R3 R8 data trap
    '{0,0,0,0,0,2'b01,1, 32'h0,         32'h0000_0000, 32'h1000_0004, 0,0}, // R6 clear on read
    '{1,0,1,0,1,2'b01,0, 32'h2000_0010, 32'h0000_0076, 32'h2000_0010, 1,0}, // R3 R8 code trap
    '{1,1,0,1,0,2'b11,0, 32'h3000_0020, 32'h0001_0097, 32'h3000_0020, 0,0}, // R4 overflow, no-fault blocks trap
    '{1,0,0,0,0,2'b00,1, 32'h4000_0030, 32'h0000_0016, 32'h4000_0030, 0,0}, // R7 read with fault
    '{0,0,0,0,0,2'b01,0, 32'hFFFF_FFFF, 32'h0000_0016, 32'h4000_0030, 0,0}, // R5 R6 hold
    '{1,1,1,1,1,2'b10,0, 32'h5000_0040, 32'h0001_00F7, 32'h5000_0040, 0,0}, // R4 R8 disabled
    '{0,0,0,0,0,2'b01,1, 32'h0,         32'h0000_0000, 32'h5000_0040, 0,0}, // R6
    '{1,1,1,1,0,2'b01,0, 32'h6000_0050, 32'h0001_00D6, 32'h6000_0050, 1,0}  // R3 R8
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    faultValid = 0; faultWrite = 0; faultExec = 0; faultAlt = 0;
    supervisor = 0; statusRead = 0; faultAddr = '0; mmuCtrl = 2'b01;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    idle();
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 status", faultStatus, 0);
    chk("R1 addr", faultAddrReg, 0);
    chk("R1 traps", {30'd0, codeTrap, dataTrap}, 0);
    rstN = 1;
    @(negedge clk);
    chk("R1 status after release", faultStatus, 0);

    for (int i = 0; i < NV; i++) begin
      faultValid = TABLE[i].flt; faultWrite = TABLE[i].wr; faultExec = TABLE[i].ex;
      faultAlt = TABLE[i].alt; supervisor = TABLE[i].sup; mmuCtrl = TABLE[i].ctl;
      statusRead = TABLE[i].rd; faultAddr = TABLE[i].addr;
      #1;
      if (TABLE[i].rd) chk("R6 rdata", statusRdata, faultStatus);
      @(negedge clk);
      chk("R2/R3/R4/R6/R7 status", faultStatus, TABLE[i].expSt);
      chk("R5 addr", faultAddrReg, TABLE[i].expAddr);
      chk("R8 codeTrap", {31'd0, codeTrap}, {31'd0, TABLE[i].expCode});
      chk("R8 dataTrap", {31'd0, dataTrap}, {31'd0, TABLE[i].expData});
    end

    // R9: trap lasts one cycle
    idle();
    @(negedge clk);
    chk("R9 code pulse ends", {31'd0, codeTrap}, 0);
    chk("R9 data low", {31'd0, dataTrap}, 0);
    // R9: back-to-back faults give separate single pulses of each kind
    faultValid = 1; faultExec = 0; faultAddr = 32'h7000_0000;
    @(negedge clk);
    chk("R9 data pulse", {30'd0, codeTrap, dataTrap}, 1);
    faultExec = 1;
    @(negedge clk);
    chk("R9 code after data", {30'd0, codeTrap, dataTrap}, 2);
    chk("R4 overflow chain", faultStatus, 32'h57);
    idle();
    @(negedge clk);
    chk("R9 both low", {30'd0, codeTrap, dataTrap}, 0);
    // R1: reset mid-run empties registers
    rstN = 0;
    @(negedge clk);
    chk("R1 mid reset status", faultStatus, 0);
    chk("R1 mid reset addr", faultAddrReg, 0);
    rstN = 1;
    @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule